// File: doc/BRIEF.md
# Key-Armed Delayed Warm Reset Generator

This block lets software on a board controller request a warm reset of the local board by writing one byte to a single control register. The register sits at byte offset 0x17 on a byte-wide parallel bus with address, write strobe, read strobe, write data and read data. Writing the key value 0x77 to it arms a countdown. Any other value is only stored and can be read back.

When the countdown expires, an active-low warm reset output is driven for a fixed number of clock cycles and is then released on a clock edge. The countdown is derived from the clock frequency, and its default of 1.5 ms falls inside the required 1 to 2 ms window. The same pulse clears the block's own register. A separate host-side reset output is never lowered by this mechanism. A synchronous active-high power-on reset overrides everything.

A busy output reports that a countdown or a pulse is in progress. While busy is high, further writes neither restart nor stretch the sequence.

Top module: `warm_rst_ctrl`

## Requirements
- R1: While `por_i` is high, `warm_rst_n_o` is 1, `busy_o` is 0, `host_rst_n_o` is 0 and `bus_rdata_o` is 0x00. After release, a read of 0x17 returns 0x00.
- R2: A write of any value other than 0x77 to address 0x17 stores that value. It does not raise `busy_o` and does not lower `warm_rst_n_o`.
- R3: A write of 0x77 to address 0x17 with `busy_o` low raises `busy_o` at the write edge. `warm_rst_n_o` falls exactly DELAY_CYC clock edges after the write edge, where DELAY_CYC = (CLK_FREQ_HZ/1000)*DELAY_US/1000. This is 150,000 cycles (1.5 ms) by default.
- R4: `warm_rst_n_o` stays low for exactly PULSE_CYC cycles (default 16) and then returns to 1. `busy_o` stays high throughout and falls on the same edge as the release.
- R5: Writes made while `busy_o` is high never restart, shorten or extend the sequence, and this includes another 0x77. During the countdown, such writes to 0x17 still update the stored value.
- R6: The stored value becomes 0x00 on the edge where `warm_rst_n_o` falls. Writes to 0x17 while the pulse is active are ignored, so later reads return 0x00.
- R7: `host_rst_n_o` is 1 whenever `por_i` was low at the previous edge, including throughout any warm reset pulse.
- R8: Reads of any address other than 0x17 return 0x00. Writes to other addresses, including 0x77, change no state and start no countdown.
- R9: `bus_rdata_o` is registered. One cycle after a read of 0x17 it carries the value stored before that edge, and it is 0x00 in every cycle that follows no read.
- R10: Asserting `por_i` during a countdown cancels it. No warm reset pulse follows, and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock of frequency CLK_FREQ_HZ |
| por_i | input | 1 | Synchronous active-high power-on reset |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data, 0x00 when no read |
| busy_o | output | 1 | Countdown or pulse in progress |
| warm_rst_n_o | output | 1 | Active-low warm reset to local subsystems |
| host_rst_n_o | output | 1 | Active-low host-side reset, follows power-on reset only |

## Verification
The hardest situations to reach from the ports are bus accesses that land on the exact edge where the countdown expires or inside the short pulse window. At the default clock, these sit 150,000 cycles after the trigger. The bench therefore instantiates the block with a scaled frequency parameter, so the same formula yields a 150-cycle countdown. It then places a second key write, ordinary writes and reads at chosen offsets inside the countdown and inside the pulse. A power-on reset is also applied in the middle of a countdown, and the bench shows that no pulse follows. A behavioural model predicts every output on every cycle.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_PULSE = 2'd2
  } seq_state_e;

  // Number of clock cycles in a delay of delay_us microseconds.
  function automatic int delay_cycles(input int clk_hz, input int delay_us);
    longint prod;
    prod = (longint'(clk_hz) / 1000) * longint'(delay_us);
    return int'(prod / 1000);
  endfunction

endpackage

// File: rtl/wrr_regfile.sv
module wrr_regfile #(
  parameter int                 ADDR_W   = 8,
  parameter int                 DATA_W   = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR = 'h17,
  parameter logic [DATA_W-1:0]  KEY      = 'h77
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              hold_i,
  output logic              fire_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              hit;
  logic [DATA_W-1:0] store_q;
  logic [DATA_W-1:0] rdata_q;

  assign hit    = (addr_i == REG_ADDR);
  assign fire_o = wr_i && hit && (wdata_i == KEY) && !hold_i;

  always_ff @(posedge clk) begin
    if (por_i) begin
      store_q <= '0;
    end else if (clr_i || hold_i) begin
      store_q <= '0;
    end else if (wr_i && hit) begin
      store_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      rdata_q <= '0;
    end else if (rd_i && hit) begin
      rdata_q <= store_q;
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  // R6: an active pulse leaves the register empty on the next edge
  assert_store_cleared_R6: assert property (@(posedge clk) disable iff (por_i)
    hold_i |=> (store_q == '0));

  // R8: reads outside the register's address give zero
  assert_foreign_read_zero_R8: assert property (@(posedge clk) disable iff (por_i)
    (rd_i && (addr_i != REG_ADDR)) |=> (rdata_o == '0));

  // R8: writes outside the register's address leave it as it was
  assert_foreign_write_ignored_R8: assert property (@(posedge clk) disable iff (por_i)
    (wr_i && (addr_i != REG_ADDR) && !clr_i && !hold_i) |=> $stable(store_q));

endmodule

// File: rtl/wrr_sequencer.sv
module wrr_sequencer
  import wrr_pkg::*;
#(
  parameter int DELAY_CYC = 150000,
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic por_i,
  input  logic fire_i,
  output logic clr_o,
  output logic hold_o,
  output logic busy_o,
  output logic warm_rst_n_o
);

  localparam int MAXC  = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              warm_n_q;
  logic              expire;

  assign expire = (state_q == SEQ_WAIT) && (cnt_q == '0);
  assign clr_o  = expire;
  assign hold_o = (state_q == SEQ_PULSE);

  always_ff @(posedge clk) begin
    if (por_i) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      warm_n_q <= 1'b1;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (fire_i) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= CNT_W'(DELAY_CYC - 1);
            busy_q  <= 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (cnt_q == '0) begin
            state_q  <= SEQ_PULSE;
            cnt_q    <= CNT_W'(PULSE_CYC - 1);
            warm_n_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_PULSE: begin
          if (cnt_q == '0) begin
            state_q  <= SEQ_IDLE;
            busy_q   <= 1'b0;
            warm_n_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          state_q  <= SEQ_IDLE;
          busy_q   <= 1'b0;
          warm_n_q <= 1'b1;
        end
      endcase
    end
  end

  assign busy_o       = busy_q;
  assign warm_rst_n_o = warm_n_q;

  // Observation counters used only by the checks below.
  logic [CNT_W:0] wait_seen_q;
  logic [CNT_W:0] low_seen_q;

  always_ff @(posedge clk) begin
    if (por_i) begin
      wait_seen_q <= '0;
      low_seen_q  <= '0;
    end else begin
      wait_seen_q <= (state_q == SEQ_WAIT) ? wait_seen_q + 1'b1 : '0;
      low_seen_q  <= (!warm_n_q) ? low_seen_q + 1'b1 : '0;
    end
  end

  // R3: the pulse starts after exactly DELAY_CYC countdown edges
  assert_delay_length_R3: assert property (@(posedge clk) disable iff (por_i)
    $fell(warm_n_q) |-> (wait_seen_q == (CNT_W+1)'(DELAY_CYC)));

  // R4: the pulse lasts exactly PULSE_CYC cycles
  assert_pulse_length_R4: assert property (@(posedge clk) disable iff (por_i)
    $rose(warm_n_q) |-> (low_seen_q == (CNT_W+1)'(PULSE_CYC)));

  // R5: once waiting, the count only steps down by one
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (por_i)
    ((state_q == SEQ_WAIT) && $past(state_q == SEQ_WAIT)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/warm_rst_ctrl.sv
module warm_rst_ctrl
  import wrr_pkg::*;
#(
  parameter int                CLK_FREQ_HZ = 100_000_000,
  parameter int                DELAY_US    = 1500,
  parameter int                PULSE_CYC   = 16,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 'h17,
  parameter logic [DATA_W-1:0] KEY         = 'h77
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              busy_o,
  output logic              warm_rst_n_o,
  output logic              host_rst_n_o
);

  localparam int DELAY_CYC = delay_cycles(CLK_FREQ_HZ, DELAY_US);

  logic fire;
  logic clr;
  logic hold;
  logic host_n_q;

  wrr_regfile #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR),
    .KEY      (KEY)
  ) regs_i (
    .clk     (clk),
    .por_i   (por_i),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .wdata_i (bus_wdata_i),
    .clr_i   (clr),
    .hold_i  (hold),
    .fire_o  (fire),
    .rdata_o (bus_rdata_o)
  );

  wrr_sequencer #(
    .DELAY_CYC (DELAY_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) seq_i (
    .clk          (clk),
    .por_i        (por_i),
    .fire_i       (fire),
    .clr_o        (clr),
    .hold_o       (hold),
    .busy_o       (busy_o),
    .warm_rst_n_o (warm_rst_n_o)
  );

  // Host-side reset follows only the power-on reset.
  always_ff @(posedge clk) begin
    host_n_q <= !por_i;
  end

  assign host_rst_n_o = host_n_q;

  // R7: the host side stays out of reset during a warm reset
  assert_host_untouched_R7: assert property (@(posedge clk) disable iff (por_i)
    !warm_rst_n_o |-> host_rst_n_o);

  // R4: busy covers the whole pulse
  assert_busy_covers_pulse_R4: assert property (@(posedge clk) disable iff (por_i)
    !warm_rst_n_o |-> busy_o);

endmodule

// File: tb/warm_rst_ctrl_tb_top.sv
module warm_rst_ctrl_tb_top;

  // Scaled clock parameter: 100 kHz * 1.5 ms gives a 150-cycle countdown.
  localparam int DLY = 150;
  localparam int PLS = 16;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       busy;
  logic       warm_n;
  logic       host_n;

  int    checks = 0;
  int    fails = 0;
  bit    started = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  warm_rst_ctrl #(
    .CLK_FREQ_HZ (100_000),
    .DELAY_US    (1500),
    .PULSE_CYC   (PLS)
  ) dut_i (
    .clk          (clk),
    .por_i        (por),
    .bus_addr_i   (addr),
    .bus_wr_i     (wr),
    .bus_rd_i     (rd),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .busy_o       (busy),
    .warm_rst_n_o (warm_n),
    .host_rst_n_o (host_n)
  );

  // Behavioural reference model
  int m_reg = 0;
  int m_rd = 0;
  bit m_warm = 1;
  bit m_busy = 0;
  bit m_host = 0;
  int m_phase = 0;
  int m_left = 0;

  always @(posedge clk) begin
    started = 1;
    if (por) begin
      m_reg = 0; m_rd = 0; m_warm = 1; m_busy = 0; m_host = 0;
      m_phase = 0; m_left = 0;
    end else begin
      m_host = 1;
      m_rd = (rd && addr == 8'h17) ? m_reg : 0;
      if (m_phase == 0) begin
        if (wr && addr == 8'h17) begin
          m_reg = wdata;
          if (wdata == 8'h77) begin
            m_phase = 1; m_left = DLY; m_busy = 1;
          end
        end
      end else if (m_phase == 1) begin
        if (wr && addr == 8'h17) m_reg = wdata;
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_phase = 2; m_left = PLS; m_warm = 0; m_reg = 0;
        end
      end else begin
        m_reg = 0;
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_phase = 0; m_warm = 1; m_busy = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rdata !== m_rd[7:0]) begin
        fails++;
        $display("FAIL %s rdata actual %h expected %h at %0t", cur_req, rdata, m_rd[7:0], $time);
      end
      checks++;
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL %s busy actual %b expected %b at %0t", cur_req, busy, m_busy, $time);
      end
      checks++;
      if (warm_n !== m_warm) begin
        fails++;
        $display("FAIL %s warm_rst_n actual %b expected %b at %0t", cur_req, warm_n, m_warm, $time);
      end
      checks++;
      if (host_n !== m_host) begin
        fails++;
        $display("FAIL %s host_rst_n actual %b expected %b at %0t", cur_req, host_n, m_host, $time);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual still running expected finished");
    finish_run();
  end

  initial begin
    // R1: power-on reset state
    cur_req = "R1";
    idle(5);
    por = 1'b0;
    rd_reg(8'h17);
    idle(2);

    // R9: no read strobe gives zero data
    cur_req = "R9";
    idle(4);

    // R2: ordinary values are stored and read back
    cur_req = "R2";
    wr_reg(8'h17, 8'hA5); rd_reg(8'h17);
    wr_reg(8'h17, 8'h00); rd_reg(8'h17);
    wr_reg(8'h17, 8'hFF); rd_reg(8'h17);
    wr_reg(8'h17, 8'h76); rd_reg(8'h17);
    wr_reg(8'h17, 8'h78); rd_reg(8'h17);
    idle(20);

    // R9: read issued on the cycle right after a write returns the new value
    cur_req = "R9";
    wr_reg(8'h17, 8'h3C);
    rd_reg(8'h17);
    idle(3);

    // R8: foreign addresses
    cur_req = "R8";
    wr_reg(8'h16, 8'h77);
    wr_reg(8'h18, 8'h77);
    wr_reg(8'h97, 8'h12);
    rd_reg(8'h16); rd_reg(8'h18); rd_reg(8'h00);
    rd_reg(8'h17);
    idle(DLY + 10);

    // R3: key write arms the countdown
    cur_req = "R3";
    wr_reg(8'h17, 8'h77);
    rd_reg(8'h17);
    idle(36);
    // R5: writes while busy
    cur_req = "R5";
    wr_reg(8'h17, 8'h77);
    idle(40);
    wr_reg(8'h17, 8'h33);
    rd_reg(8'h17);
    wr_reg(8'h16, 8'h77);
    idle(64);
    // R6: register cleared, writes ignored during pulse
    cur_req = "R6";
    wr_reg(8'h17, 8'h55);
    rd_reg(8'h17);
    // R7: host side untouched during pulse
    cur_req = "R7";
    idle(8);
    cur_req = "R4";
    idle(20);
    cur_req = "R6";
    rd_reg(8'h17);
    idle(5);

    // R10: power-on reset cancels a countdown
    cur_req = "R10";
    wr_reg(8'h17, 8'h77);
    idle(60);
    @(negedge clk); por = 1'b1;
    @(negedge clk); @(negedge clk); por = 1'b0;
    idle(DLY + 40);
    rd_reg(8'h17);

    // R4: full sequence again, with accesses around the expiry edge
    cur_req = "R4";
    wr_reg(8'h17, 8'h77);
    idle(DLY - 5);
    for (int i = 0; i < 6; i++) begin
      rd_reg(8'h17);
    end
    wr_reg(8'h17, 8'h77);
    idle(PLS + 10);
    cur_req = "R3";
    wr_reg(8'h17, 8'h77);
    idle(DLY + PLS + 10);
    rd_reg(8'h17);
    idle(3);

    finish_run();
  end

endmodule